// File: doc/BRIEF.md
# Auto-Reload 8-bit Event Timer

This block is an 8-bit up-counter that sits on a simple CPU register bus. One bus address serves two registers. A write at that address sets a reload value and copies the same value into the counter straight away. A read at that address returns the live count. Reads have no effect on counting.

A 3-bit select input picks what advances the counter. There are six internal prescaler taps, the synchronized rising edges of an external event pin, and a stop setting. The counter can run in a wrap-to-zero mode or in an auto-reload mode. In auto-reload mode the overflow period can be set anywhere from 1 to 256 counted events. Every overflow sets a sticky interrupt request, and a dedicated clear strobe drops it.

Top module: `reload_timer8`

## Requirements
- R1: While reset is asserted and after it is released, the count reads 0x00, the reload value is 0x00 and `irqReq` is 0.
- R2: A read with `busAddr` equal to `TIMER_ADDR` (default 0) returns the current count. Any other address reads 0x00. Reading never changes the count sequence.
- R3: A write with `busAddr` equal to `TIMER_ADDR` stores `busWdata` as the reload value and places it in the counter at the same clock edge. Writes to any other address leave the count and the reload value unchanged.
- R4: When a count event and a timer write fall in the same cycle, the counter takes the written value and that count event is lost.
- R5: For select codes n = 0..5, the counter advances by one in each cycle in which the low 2n+1 bits of a free-running cycle count are all ones. That count is cleared by reset and increases by one every clock. This gives divide ratios of 2, 8, 32, 128, 512 and 2048.
- R6: With select code 6, `evtIn` passes through a two-stage synchronizer. The counter advances once for each rising edge of `evtIn`, two clock edges after the edge that first samples it high. It advances at most once per clock, and holding `evtIn` high adds no further counts.
- R7: With select code 7, the counter does not count. Only a write can change it.
- R8: With `autoReload` = 0, a count event at 0xFF takes the counter to 0x00.
- R9: With `autoReload` = 1, a count event at 0xFF loads the reload value. This makes the overflow period 256 minus the reload value, in counted events (0xFF gives 1, 0x00 gives 256).
- R10: Every overflow sets `irqReq` at the same edge that the counter wraps or reloads, in both modes. `irqReq` then stays at 1.
- R11: `irqClr` clears `irqReq` at the next edge, unless an overflow occurs in that same cycle, in which case `irqReq` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 8 | Write data (reload value) |
| busRdata | output | 8 | Read data (count at the timer address) |
| clkSel | input | 3 | Count source: 0..5 prescaler taps, 6 external event, 7 stop |
| autoReload | input | 1 | 1 = reload on overflow, 0 = wrap to zero |
| evtIn | input | 1 | Asynchronous external event input |
| irqClr | input | 1 | Interrupt request clear strobe |
| irqReq | output | 1 | Sticky overflow interrupt request |

## Verification
Several rules are checked on every cycle. These are the load-on-write value, the plus-one step, the wrap and reload targets on overflow, the held count when nothing happens, the flag set and clear priority, the silent stop code, and the rule that an external edge yields no back-to-back count events. Other behaviour can only be shown by the bench's scenarios against its cycle model. This covers the exact prescaler phase after reset, the synchronizer latency, the address decode of reads and writes, and overflow periods measured over many events. The scenarios also cover the mix of random writes, clears, mode and source changes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic loadStb;   // timer write: load reload and counter
    logic countStb;  // one count event this cycle
    logic clearStb;  // interrupt clear request
  } ctlStb_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int TIMER_ADDR    = 0,
  parameter int SEL_W         = 3,
  parameter int NUM_TAPS      = 6,
  parameter int DIV_BASE_LOG2 = 1,
  parameter int DIV_STEP_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [SEL_W-1:0]  clkSel,
  input  logic              evtIn,
  input  logic              irqClr,
  output logic              addrHit,
  output ctlStb_t           stb
);
  localparam int PRE_W = DIV_BASE_LOG2 + DIV_STEP_LOG2 * (NUM_TAPS - 1);
  localparam logic [SEL_W-1:0] SEL_EXT  = SEL_W'(NUM_TAPS);
  localparam logic [SEL_W-1:0] SEL_STOP = SEL_W'(NUM_TAPS + 1);

  logic [PRE_W-1:0]    preCnt;
  logic [NUM_TAPS-1:0] tapPulse;
  logic                evtS1, evtS2, evtS3;
  logic                evtEdge;
  logic                tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      evtS1  <= 1'b0;
      evtS2  <= 1'b0;
      evtS3  <= 1'b0;
    end else begin
      preCnt <= preCnt + 1'b1;
      evtS1  <= evtIn;
      evtS2  <= evtS1;
      evtS3  <= evtS2;
    end
  end

  assign evtEdge = evtS2 & ~evtS3;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int TAP_LOG2 = DIV_BASE_LOG2 + DIV_STEP_LOG2 * i;
    assign tapPulse[i] = &preCnt[TAP_LOG2-1:0];
  end

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++)
      if (clkSel == SEL_W'(i)) tick = tapPulse[i];
    if (clkSel == SEL_EXT) tick = evtEdge;
  end

  assign addrHit      = (busAddr == ADDR_W'(TIMER_ADDR));
  assign stb.loadStb  = busWe & addrHit;
  assign stb.countStb = tick;
  assign stb.clearStb = irqClr;

  // R7
  stop_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == SEL_STOP) |-> !stb.countStb);

  // R6
  evt_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == SEL_EXT && stb.countStb) |=> !(clkSel == SEL_EXT && stb.countStb));
endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          stb,
  input  logic [CNT_W-1:0] wdata,
  input  logic             autoReload,
  output logic [CNT_W-1:0] cnt,
  output logic             irqFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] reloadReg;
  logic             atMax;
  logic             ovf;

  assign atMax = (cnt == CNT_MAX);
  assign ovf   = stb.countStb & ~stb.loadStb & atMax;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      reloadReg <= '0;
    end else if (stb.loadStb) begin
      cnt       <= wdata;
      reloadReg <= wdata;
    end else if (stb.countStb) begin
      if (atMax) cnt <= autoReload ? reloadReg : '0;
      else       cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             irqFlag <= 1'b0;
    else if (ovf)          irqFlag <= 1'b1;
    else if (stb.clearStb) irqFlag <= 1'b0;
  end

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadStb |=> cnt == $past(wdata));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countStb && !stb.loadStb && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countStb && !stb.loadStb && cnt == CNT_MAX && !autoReload) |=> cnt == '0);

  // R9
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countStb && !stb.loadStb && cnt == CNT_MAX && autoReload) |=> cnt == $past(reloadReg));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.countStb && !stb.loadStb) |=> $stable(cnt));

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countStb && !stb.loadStb && cnt == CNT_MAX) |=> irqFlag);

  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clearStb && !(stb.countStb && !stb.loadStb && cnt == CNT_MAX)) |=> !irqFlag);
endmodule

// File: rtl/reload_timer8.sv
module reload_timer8
  import tmr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int TIMER_ADDR = 0,
  parameter int CNT_W      = 8,
  parameter int SEL_W      = 3,
  parameter int NUM_TAPS   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  input  logic [SEL_W-1:0]  clkSel,
  input  logic              autoReload,
  input  logic              evtIn,
  input  logic              irqClr,
  output logic              irqReq
);
  ctlStb_t          stb;
  logic             addrHit;
  logic [CNT_W-1:0] cnt;

  tmr_ctrl #(
    .ADDR_W(ADDR_W), .TIMER_ADDR(TIMER_ADDR), .SEL_W(SEL_W),
    .NUM_TAPS(NUM_TAPS), .DIV_BASE_LOG2(1), .DIV_STEP_LOG2(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .clkSel(clkSel), .evtIn(evtIn), .irqClr(irqClr),
    .addrHit(addrHit), .stb(stb)
  );

  tmr_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .autoReload(autoReload), .cnt(cnt), .irqFlag(irqReq)
  );

  assign busRdata = addrHit ? cnt : '0;
endmodule

// File: tb/tb_reload_timer8.sv
`timescale 1ns/1ps
module tb_reload_timer8;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [2:0] clkSel = 3'd7;
  logic       autoReload = 1'b0;
  logic       evtIn = 1'b0;
  logic       irqClr = 1'b0;
  logic       irqReq;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  reload_timer8 dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .clkSel(clkSel),
    .autoReload(autoReload), .evtIn(evtIn), .irqClr(irqClr), .irqReq(irqReq)
  );

  // Reference model built from the requirements
  logic [10:0] mCyc;
  logic        m1, m2, m3;
  logic [7:0]  mCnt, mRel;
  logic        mIrq;
  logic        mTick, mOvf;

  function automatic logic tapHit(input logic [10:0] c, input int n);
    logic [10:0] mask;
    mask = 11'((1 << (2 * n + 1)) - 1);
    return (c & mask) == mask;
  endfunction

  function automatic logic [7:0] expRead(input logic [3:0] a, input logic [7:0] c);
    return (a == 4'd0) ? c : 8'h00;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCyc <= '0; m1 <= 0; m2 <= 0; m3 <= 0;
      mCnt <= '0; mRel <= '0; mIrq <= 0;
    end else begin
      mTick = 1'b0;
      if (clkSel < 3'd6) mTick = tapHit(mCyc, int'(clkSel));
      else if (clkSel == 3'd6) mTick = m2 & ~m3;
      mOvf = 1'b0;
      mCyc <= mCyc + 1'b1;
      m1 <= evtIn; m2 <= m1; m3 <= m2;
      if (busWe && busAddr == 4'd0) begin
        mCnt <= busWdata; mRel <= busWdata;
      end else if (mTick) begin
        if (mCnt == 8'hFF) begin
          mOvf = 1'b1;
          mCnt <= autoReload ? mRel : 8'h00;
        end else mCnt <= mCnt + 1'b1;
      end
      if (mOvf) mIrq <= 1'b1;
      else if (irqClr) mIrq <= 1'b0;
    end
  end

  task automatic chk(input string req);
    logic [7:0] e;
    e = expRead(busAddr, mCnt);
    vectors++;
    if (busRdata !== e || irqReq !== mIrq) begin
      fails++;
      $display("FAIL %s: rdata=%h exp=%h irqReq=%b exp=%b", req, busRdata, e, irqReq, mIrq);
    end
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    @(negedge clk);
    chk(req);
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(req);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string req);
    busAddr = a; busWe = 1'b1; busWdata = d;
    cyc(req);
    busWe = 1'b0; busAddr = 4'd0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d exp<=%0d", cycles, 150000);
      finish();
    end
  end

  initial begin
    void'($urandom(32'h1D5EED));
    // R1: reset state
    run(3, "R1");
    @(negedge clk);
    rstN = 1'b1;
    chk("R1");
    run(2, "R1");

    // R3: write loads counter and reload; other addresses ignored
    wr(4'd0, 8'h5A, "R3");
    run(2, "R3");
    wr(4'd3, 8'h11, "R3");
    busAddr = 4'd3;
    cyc("R2");
    busAddr = 4'd0;
    cyc("R3");

    // R7: stop code
    clkSel = 3'd7;
    run(20, "R7");

    // R5: internal taps
    for (int n = 0; n < 6; n++) begin
      clkSel = 3'(n);
      run(n == 5 ? 4200 : 600, "R5");
    end

    // R6: external event edges, short and long pulses
    clkSel = 3'd6;
    for (int k = 0; k < 30; k++) begin
      evtIn = ~evtIn;
      run(1 + (k % 4), "R6");
    end
    evtIn = 1'b1;
    run(20, "R6");
    evtIn = 1'b0;
    run(5, "R6");

    // R8 + R10: free-running wrap sets flag
    autoReload = 1'b0;
    clkSel = 3'd7;
    wr(4'd0, 8'hFC, "R8");
    clkSel = 3'd0;
    run(20, "R8");
    run(4, "R10");

    // R11: plain clear, then clear colliding with overflows
    clkSel = 3'd7;
    irqClr = 1'b1;
    cyc("R11");
    irqClr = 1'b0;
    run(3, "R11");
    autoReload = 1'b1;
    wr(4'd0, 8'hFF, "R9");
    clkSel = 3'd0;
    irqClr = 1'b1;
    run(10, "R11");
    irqClr = 1'b0;

    // R9: auto-reload periods
    wr(4'd0, 8'hF0, "R9");
    run(100, "R9");
    wr(4'd0, 8'h00, "R9");
    run(1100, "R9");

    // R4: write every cycle against fast tick
    clkSel = 3'd0;
    for (int k = 0; k < 12; k++) wr(4'd0, 8'(8'hF8 + k), "R4");
    run(10, "R4");

    // Random mix
    for (int k = 0; k < 20000; k++) begin
      busAddr = ($urandom % 2) ? 4'd0 : 4'($urandom);
      busWe = ($urandom % 16) == 0;
      busWdata = ($urandom % 3 == 0) ? 8'hFF - 8'($urandom % 4) : 8'($urandom);
      irqClr = ($urandom % 8) == 0;
      if ($urandom % 4 == 0) evtIn = ~evtIn;
      if ($urandom % 200 == 0) clkSel = 3'($urandom);
      if ($urandom % 300 == 0) autoReload = ~autoReload;
      cyc("R2");
    end
    busWe = 1'b0; irqClr = 1'b0;
    run(5, "R2");
    finish();
  end
endmodule